// File: doc/BRIEF.md
# Per-Line Interrupt Trigger Conditioner

This block sits between a set of external interrupt wires and an interrupt controller. Each of its lines is first brought into the local clock domain by a two-flop synchroniser. A pair of configuration bits per line then selects one of four behaviours: active-high level, active-low level, rising edge or falling edge. Level lines pass the synchronised input, inverted where needed, straight to the conditioned request output. Edge lines latch each qualifying transition in a raw status bit, and that bit drives the request until the host acknowledges it.

The lines are grouped into banks that share a 32-bit register window. Each configuration bit can be set or cleared on its own through dedicated write-one-to-set and write-one-to-clear addresses. Edges are acknowledged by writing ones to the raw status address. At start-up the host normally writes all ones to raw status to discard anything already pending.

Top module: `trig_cond_unit`

## Requirements
- R1: Bank b occupies 32 bytes at address 0x200 + 0x20*b. Its word offsets are 0x00 conditioned request (read), 0x04 raw edge status (read, write one to clear), 0x08 rise-select (read), 0x0C fall-select (read), 0x10 rise-select set, 0x14 rise-select clear, 0x18 fall-select set and 0x1C fall-select clear. Bit i of bank b is line 32*b+i. Any read outside the bank windows returns zero.
- R2: Writing to a set address ORs the written ones into the selected configuration register. Writing to a clear address removes them. Zero bits leave configuration bits unchanged.
- R3: After reset all configuration bits and all raw status bits are 0. Every line is therefore active-high level, and with all inputs low every request is 0.
- R4: The mode of a line is {rise,fall}: 00 active-high level, 11 active-low level, 10 rising edge, 01 falling edge.
- R5: On a rising-edge line, a synchronised 0-to-1 transition sets its raw bit. The request equals the raw bit, so it stays high after the input falls again until the bit is acknowledged.
- R6: On a falling-edge line, a synchronised 1-to-0 transition sets its raw bit. The request equals the raw bit.
- R7: An active-high level line requests while its input is high. An active-low level line requests while its input is low.
- R8: Writing ones to the raw status address clears those raw bits. Zero bits leave the raw bits unchanged.
- R9: Raw bits never become set on lines in a level mode, and acknowledge writes do not change the request of a level line.
- R10: If an edge is detected in the same cycle as an acknowledge of that bit, the raw bit stays set.
- R11: A level request reflects an input change two rising clock edges after the input changes. An edge request reflects it three rising clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_BANKS*DATA_W | Asynchronous interrupt inputs, line k at bit k |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_req | output | N_BANKS*DATA_W | Conditioned request per line |

## Verification
The bench builds the block with its default parameters: two banks of 32 lines at base 0x200 with a 0x20 stride. This size is small enough to check every line of both banks at once through bank-wide masks. Every line is swept through each of the four uniform modes and through an interleaved map that places all four modes in neighbouring bits. For each mode map, vector input patterns drive rising and falling transitions on every line, and a model in the bench computes the expected requests and raw bits arithmetically. Separate cycle-exact sequences cover the synchroniser latency of each mode class and the collision of an acknowledge with a new edge.

// File: rtl/trig_pkg.sv
// Package trig_pkg
// Shared register offsets and the per-line trigger mode encoding.
// Assumes a bank window of 32 bytes with word-aligned registers.
package trig_pkg;

    localparam int unsigned OFF_W = 5;

    localparam logic [OFF_W-1:0] OFF_REQ      = 5'h00;
    localparam logic [OFF_W-1:0] OFF_RAW      = 5'h04;
    localparam logic [OFF_W-1:0] OFF_RISE     = 5'h08;
    localparam logic [OFF_W-1:0] OFF_FALL     = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_RISE_SET = 5'h10;
    localparam logic [OFF_W-1:0] OFF_RISE_CLR = 5'h14;
    localparam logic [OFF_W-1:0] OFF_FALL_SET = 5'h18;
    localparam logic [OFF_W-1:0] OFF_FALL_CLR = 5'h1C;

    // Mode is {rise_select, fall_select}
    typedef enum logic [1:0] {
        MODE_LEVEL_HIGH = 2'b00,
        MODE_EDGE_FALL  = 2'b01,
        MODE_EDGE_RISE  = 2'b10,
        MODE_LEVEL_LOW  = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/trig_sync.sv
// Module trig_sync
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a slow, independent wire (no bus coherency needed).
module trig_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Capture the asynchronous inputs, then retime once more
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/trig_setclr.sv
// Module trig_setclr
// A configuration register updated by write-one-to-set and write-one-to-clear strobes.
// Assumes set and clear are never asserted together (distinct addresses).
module trig_setclr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Merge ones in on set, strip them on clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_we) begin
            q <= q | wdata;
        end else if (clr_we) begin
            q <= q & ~wdata;
        end
    end

endmodule

// File: rtl/trig_bank.sv
// Module trig_bank
// One bank of trigger lines: synchroniser, mode registers, edge detection,
// raw edge latch, conditioned requests and the bank's register read data.
// Assumes wr_en is already qualified by the bank address decode.
module trig_bank
    import trig_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     irq_in,
    output logic [W-1:0]     req,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] smp;
    logic [W-1:0] smp_prev;
    logic [W-1:0] rise_cfg;
    logic [W-1:0] fall_cfg;
    logic [W-1:0] raw;
    logic [W-1:0] ev;
    logic [W-1:0] is_edge;
    logic [W-1:0] lvl;
    logic [W-1:0] ack;

    trig_sync #(.W(W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (smp)
    );

    // Hold the previous synchronised sample for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) smp_prev <= '0;
        else        smp_prev <= smp;
    end

    trig_setclr #(.W(W)) i_rise_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en && (off == OFF_RISE_SET)),
        .clr_we (wr_en && (off == OFF_RISE_CLR)),
        .wdata  (wdata),
        .q      (rise_cfg)
    );

    trig_setclr #(.W(W)) i_fall_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en && (off == OFF_FALL_SET)),
        .clr_we (wr_en && (off == OFF_FALL_CLR)),
        .wdata  (wdata),
        .q      (fall_cfg)
    );

    for (genvar i = 0; i < W; i++) begin : g_line
        trig_mode_e mode;
        logic       l_ev;
        logic       l_edge;
        logic       l_lvl;

        assign mode = trig_mode_e'({rise_cfg[i], fall_cfg[i]});

        // Decode the line mode into an event strobe or a level value
        always_comb begin
            l_ev   = 1'b0;
            l_edge = 1'b0;
            l_lvl  = 1'b0;
            case (mode)
                MODE_EDGE_RISE: begin
                    l_edge = 1'b1;
                    l_ev   = smp[i] & ~smp_prev[i];
                end
                MODE_EDGE_FALL: begin
                    l_edge = 1'b1;
                    l_ev   = ~smp[i] & smp_prev[i];
                end
                MODE_LEVEL_LOW:  l_lvl = ~smp[i];
                default:         l_lvl = smp[i];
            endcase
        end

        assign ev[i]      = l_ev;
        assign is_edge[i] = l_edge;
        assign lvl[i]     = l_lvl;
    end

    assign ack = (wr_en && (off == OFF_RAW)) ? wdata : '0;

    // Latch edge events; an event in the acknowledge cycle wins
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~ack) | ev;
    end

    assign req = (is_edge & raw) | (~is_edge & lvl);

    // Register read mux for this bank; write-only offsets read as zero
    always_comb begin
        case (off)
            OFF_REQ:  rd_data = req;
            OFF_RAW:  rd_data = raw;
            OFF_RISE: rd_data = rise_cfg;
            OFF_FALL: rd_data = fall_cfg;
            default:  rd_data = '0;
        endcase
    end

    // R2: a set write leaves all written ones present in the rise register
    a_r2_rise_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_RISE_SET) |=> ((rise_cfg & $past(wdata)) == $past(wdata)));

    // R2: a clear write leaves none of the written ones in the fall register
    a_r2_fall_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_FALL_CLR) |=> ((fall_cfg & $past(wdata)) == '0));

    // R5 / R6 / R10: a detected edge is always latched, acknowledge or not
    a_r5_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((raw & $past(ev)) == $past(ev)));

    // R8: acknowledged bits without a new event are cleared
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |=> ((raw & $past(ack & ~ev)) == '0));

    // R9: no raw bit is newly set on a line that was in a level mode
    a_r9_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge != '1) |=> ((raw & ~$past(raw) & ~$past(is_edge)) == '0));

endmodule

// File: rtl/trig_cond_unit.sv
// Module trig_cond_unit
// Top of the trigger conditioner: decodes the register window into banks,
// instantiates one trig_bank per bank and merges the read data.
// Assumes bank windows do not overlap (BANK_STRIDE >= 32).
module trig_cond_unit
    import trig_pkg::*;
#(
    parameter int unsigned N_BANKS     = 2,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BASE_ADDR   = 32'h200,
    parameter int unsigned BANK_STRIDE = 32'h20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_BANKS*DATA_W-1:0] irq_in,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [N_BANKS*DATA_W-1:0] irq_req
);

    localparam int unsigned WIN_BYTES = 1 << OFF_W;

    logic [N_BANKS-1:0] hit;
    logic [DATA_W-1:0]  bank_rd [N_BANKS];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(BASE_ADDR + b * BANK_STRIDE);

        logic [ADDR_W-1:0] rel;

        assign rel    = reg_addr - BANK_BASE;
        assign hit[b] = (rel < ADDR_W'(WIN_BYTES)) && (rel[1:0] == 2'b00);

        trig_bank #(.W(DATA_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && hit[b]),
            .off     (rel[OFF_W-1:0]),
            .wdata   (reg_wdata),
            .irq_in  (irq_in[b*DATA_W +: DATA_W]),
            .req     (irq_req[b*DATA_W +: DATA_W]),
            .rd_data (bank_rd[b])
        );
    end

    // Merge the read data of whichever bank the address falls in
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (hit[b]) reg_rdata = reg_rdata | bank_rd[b];
        end
    end

    // R1: an address selects at most one bank
    a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_trig_cond_unit.sv
module test_trig_cond_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int W  = 32;
    localparam int AW = 12;

    localparam logic [4:0] S_REQ      = 5'h00;
    localparam logic [4:0] S_RAW      = 5'h04;
    localparam logic [4:0] S_RISE     = 5'h08;
    localparam logic [4:0] S_FALL     = 5'h0C;
    localparam logic [4:0] S_RISE_SET = 5'h10;
    localparam logic [4:0] S_RISE_CLR = 5'h14;
    localparam logic [4:0] S_FALL_SET = 5'h18;
    localparam logic [4:0] S_FALL_CLR = 5'h1C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*W-1:0]   irq_in = '0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [W-1:0]      reg_wdata = '0;
    logic [W-1:0]      reg_rdata;
    logic [NB*W-1:0]   irq_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_rise [NB];
    logic [W-1:0] m_fall [NB];
    logic [W-1:0] m_raw  [NB];

    logic [NB*W-1:0] pats [6] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                  64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
                                  64'hFFFF_0000_0F0F_F0F0, 64'h0};

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_cond_unit i_trig_cond_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    function automatic logic [AW-1:0] adr(input int b, input logic [4:0] off);
        return AW'(32'h200 + 32'(b) * 32'h20 + 32'(off));
    endfunction

    function automatic logic [W-1:0] exp_req(input int b);
        logic [W-1:0] edge_m;
        logic [W-1:0] lvl;
        edge_m = m_rise[b] ^ m_fall[b];
        lvl    = irq_in[b*W +: W] ^ (m_rise[b] & m_fall[b]);
        return (edge_m & m_raw[b]) | (~edge_m & lvl);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_cfg(input int b, input logic [W-1:0] r, input logic [W-1:0] f);
        wr(adr(b, S_RISE_CLR), '1);
        wr(adr(b, S_FALL_CLR), '1);
        wr(adr(b, S_RISE_SET), r);
        wr(adr(b, S_FALL_SET), f);
        m_rise[b] = r;
        m_fall[b] = f;
    endtask

    task automatic ack(input int b, input logic [W-1:0] mask);
        wr(adr(b, S_RAW), mask);
        m_raw[b] = m_raw[b] & ~mask;
    endtask

    task automatic drive(input logic [NB*W-1:0] nv);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            logic [W-1:0] o;
            logic [W-1:0] n;
            o = irq_in[b*W +: W];
            n = nv[b*W +: W];
            m_raw[b] = m_raw[b] | (m_rise[b] & ~m_fall[b] & ~o & n)
                                | (m_fall[b] & ~m_rise[b] & o & ~n);
        end
        irq_in = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(adr(b, S_REQ), v);
            check($sformatf("%s bank%0d request", tag, b), v, exp_req(b));
            rd(adr(b, S_RAW), v);
            check($sformatf("%s bank%0d raw", tag, b), v, m_raw[b]);
            check($sformatf("%s bank%0d irq_req", tag, b), irq_req[b*W +: W], exp_req(b));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        for (int b = 0; b < NB; b++) begin
            m_rise[b] = '0;
            m_fall[b] = '0;
            m_raw[b]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        check_all("R3 reset");
        for (int b = 0; b < NB; b++) begin
            rd(adr(b, S_RISE), v);
            check("R3 rise-select reset", v, '0);
            rd(adr(b, S_FALL), v);
            check("R3 fall-select reset", v, '0);
        end

        // R1 / R2: set and clear registers, bank placement
        wr(adr(0, S_RISE_SET), 32'hCCCC_CCCC);
        wr(adr(1, S_RISE_SET), 32'h0F0F_0F0F);
        wr(adr(1, S_RISE_CLR), 32'h00FF_00FF);
        wr(adr(1, S_FALL_SET), 32'h3333_3333);
        wr(adr(1, S_FALL_SET), 32'h0000_0000);
        rd(adr(0, S_RISE), v);
        check("R2 bank0 rise set", v, 32'hCCCC_CCCC);
        rd(adr(0, S_FALL), v);
        check("R1 bank0 fall untouched", v, 32'h0);
        rd(adr(1, S_RISE), v);
        check("R2 bank1 rise set then clear", v, 32'h0F00_0F00);
        rd(adr(1, S_FALL), v);
        check("R2 bank1 fall set", v, 32'h3333_3333);
        rd(adr(1, S_RISE_SET), v);
        check("R1 write-only offset reads zero", v, 32'h0);
        rd(12'h000, v);
        check("R1 unmapped low read", v, 32'h0);
        rd(12'h240, v);
        check("R1 unmapped high read", v, 32'h0);

        // R4 / R5 / R6 / R7 / R8 / R9: sweep mode maps and input patterns
        for (int k = 0; k < 5; k++) begin
            logic [W-1:0] r0;
            logic [W-1:0] f0;
            if (k < 4) begin
                r0 = {W{k[1]}};
                f0 = {W{k[0]}};
            end else begin
                r0 = 32'hCCCC_CCCC;
                f0 = 32'hAAAA_AAAA;
            end
            set_cfg(0, r0, f0);
            set_cfg(1, f0, r0);
            ack(0, '1);
            ack(1, '1);
            check_all($sformatf("R8 map%0d initial ack", k));
            for (int p = 0; p < 6; p++) begin
                drive(pats[p]);
                check_all($sformatf("R4/R5/R6/R7 map%0d pattern%0d", k, p));
            end
            ack(0, 32'h0000_FFFF);
            ack(1, '1);
            @(negedge clk);
            check_all($sformatf("R8/R9 map%0d partial ack", k));
        end

        // R11: latency of level and edge requests
        set_cfg(0, '1, '0);
        set_cfg(1, '0, '0);
        drive('0);
        ack(0, '1);
        @(negedge clk);
        irq_in = '1;
        m_raw[0] = '1;
        @(negedge clk);
        check("R11 level not yet after one edge", irq_req[63:32], 32'h0);
        @(negedge clk);
        check("R11 level after two edges", irq_req[63:32], '1);
        check("R11 edge not yet after two edges", irq_req[31:0], 32'h0);
        @(negedge clk);
        check("R11 edge after three edges", irq_req[31:0], '1);

        // R10: acknowledge in the same cycle as a new edge
        ack(0, '1);
        drive('0);
        ack(0, '1);
        @(negedge clk);
        irq_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = adr(0, S_RAW);
        reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        m_raw[0] = 32'h1;
        rd(adr(0, S_RAW), v);
        check("R10 edge wins over same-cycle ack", v, 32'h1);
        check("R10 request held", irq_req[31:0], 32'h1);
        ack(0, 32'h1);
        rd(adr(0, S_RAW), v);
        check("R8 later ack clears", v, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule